// File: doc/BRIEF.md
# Far-End Alarm Code Qualifier with Interrupt Register

This block receives far-end alarm and control code words that have already been extracted from the line, one six-bit word per strobe. It keeps a history of the most recent ten words. From that history it decides when a code has been seen often enough to count as established, and when an established code has gone away. Each decision is latched as a sticky event flag. A host reads these flags, and masks them, through a single byte-wide register on a simple address and read/write strobe bus. The host services one active-high interrupt line.

The last established code is held on an output port so that the host or nearby logic can act on it. It stays on that port after the code goes away, because it also serves as the reference that stops the same code from being reported twice in a row. Window bookkeeping, the two decisions, read-to-clear status and the enable bits all live inside the block. Code extraction and every other register belong to other blocks.

Top module: `feac_monitor`

## Requirements
- R1: When a strobe brings code X, and X fills at least 8 of the 10 newest window slots (the new word included), and X is allowed by R2, the block validates X. At the next clock edge it sets bit 0 (validation status) and bit 4 (code-up flag) of the register at address 0x13, and the code output shows X.
- R2: A code equal to the most recently validated code is never validated again, whether that code is still up or has been removed. Before the first validation, any code may be validated.
- R3: While a code is up, a strobe that leaves at least 3 of the 10 newest slots holding a different code removes it. This sets bit 2 (removal status) and clears bit 4. The code output keeps its value.
- R4: A read with address 0x13 returns bit 0 validation status, bit 1 validation enable, bit 2 removal status, bit 3 removal enable, bit 4 code-up flag, and zeros in bits 7..5. Any other address, or no read strobe, returns 0x00.
- R5: A read strobe at address 0x13 clears both status bits at the clock edge that ends the read. A read at any other address clears nothing.
- R6: A write strobe at address 0x13 loads bit 1 and bit 3 of the write data into the two enables. A 1 enables the interrupt and a 0 disables it. All other written bits have no effect.
- R7: The interrupt output is high exactly while (bit 0 AND bit 1) OR (bit 2 AND bit 3). It stays high until a read clears the status or the enable is cleared.
- R8: When an event and a clearing read fall in the same cycle, the read returns the value from before the event, and the event's status bit is set afterwards.
- R9: Status bits record events while their enables are 0. With an enable at 0, that source never raises the interrupt.
- R10: After synchronous reset, every register bit reads 0, the interrupt is low and the code output is 0. Without a strobe, no decision state changes.
- R11: The window counts only words received since reset. With fewer than 8 words received, nothing can be validated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_stb | input | 1 | One-cycle strobe marking a new code word |
| code_in | input | 6 | Received code word |
| addr | input | 8 | Host register address |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Host read data (combinational) |
| irq | output | 1 | Active-high level interrupt |
| valid_code | output | 6 | Most recently validated code |

## Verification
A wrong window count or a wrong reference code shows up as validation or removal occurring one strobe early or late. The first read after that strobe shows it in bits 0, 2 and 4. The code output shows it at the next edge. Each threshold is driven exactly to its boundary, one word short and then at the limit, so a count that is off by one is caught at that strobe. Any mistake in the clear-on-read or set-wins ordering shows at the next read, and the interrupt line shows it in the cycle after the event.

// File: rtl/feac_pkg.sv
package feac_pkg;
    localparam int CODE_W     = 6;
    localparam int WIN        = 10;
    localparam int CNT_W      = $clog2(WIN + 1);
    localparam int VALID_MIN  = 8;
    localparam int REMOVE_MIN = 3;
    localparam int ADDR_W     = 8;
    localparam logic [ADDR_W-1:0] REG_ADDR = 8'h13;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // register image, bit 7 down to bit 0
    typedef struct packed {
        logic [2:0] spare;
        logic       code_up;
        logic       rem_en;
        logic       rem_st;
        logic       val_en;
        logic       val_st;
    } ctl_reg_t;

    typedef struct packed {
        logic validate;
        logic remove;
    } feac_evt_t;

    function automatic logic at_least(input cnt_t cnt, input int limit);
        return int'(cnt) >= limit;
    endfunction
endpackage

// File: rtl/feac_window.sv
module feac_window
    import feac_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int WN = WIN,
    parameter int NW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic [CW-1:0] code_in,
    input  logic [CW-1:0] ref_code,
    output logic [NW-1:0] match_cnt,
    output logic [NW-1:0] diff_cnt
);
    logic [CW-1:0] hist     [WN];
    logic [WN-1:0] fill;
    logic [CW-1:0] win_code [WN];
    logic [WN-1:0] win_fill;

    // window as it will be after this strobe: incoming word in slot 0
    assign win_code[0] = code_in;
    assign win_fill[0] = 1'b1;
    for (genvar g = 1; g < WN; g++) begin : g_slot
        assign win_code[g] = hist[g-1];
        assign win_fill[g] = fill[g-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
            for (int i = 0; i < WN; i++) hist[i] <= '0;
        end else if (stb) begin
            fill <= win_fill;
            for (int i = 0; i < WN; i++) hist[i] <= win_code[i];
        end
    end

    always_comb begin
        match_cnt = '0;
        diff_cnt  = '0;
        for (int i = 0; i < WN; i++) begin
            if (win_fill[i]) begin
                if (win_code[i] == code_in)  match_cnt = match_cnt + NW'(1);
                if (win_code[i] != ref_code) diff_cnt  = diff_cnt + NW'(1);
            end
        end
    end

    // R11
    win_cap_chk: assert property (@(posedge clk) disable iff (rst)
        !fill[0] |-> (match_cnt == NW'(1)));
endmodule

// File: rtl/feac_decide.sv
module feac_decide
    import feac_pkg::*;
#(
    parameter int CW   = CODE_W,
    parameter int NW   = CNT_W,
    parameter int VMIN = VALID_MIN,
    parameter int RMIN = REMOVE_MIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic [CW-1:0] code_in,
    input  logic [NW-1:0] match_cnt,
    input  logic [NW-1:0] diff_cnt,
    output logic          code_up,
    output logic [CW-1:0] code_held,
    output feac_evt_t     evt
);
    logic seen;

    always_comb begin
        evt.validate = stb && at_least(match_cnt, VMIN)
                       && (!seen || code_in != code_held);
        evt.remove   = stb && code_up && at_least(diff_cnt, RMIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_up   <= 1'b0;
            code_held <= '0;
            seen      <= 1'b0;
        end else if (evt.validate) begin
            code_up   <= 1'b1;
            code_held <= code_in;
            seen      <= 1'b1;
        end else if (evt.remove) begin
            code_up   <= 1'b0;
        end
    end

    // R1
    validate_up_chk: assert property (@(posedge clk) disable iff (rst)
        evt.validate |=> (code_up && code_held == $past(code_in)));
    // R3
    remove_down_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.remove && !evt.validate) |=> (!code_up && $stable(code_held)));
    // R10
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> ($stable(code_held) && $stable(code_up)));
endmodule

// File: rtl/feac_regs.sv
module feac_regs
    import feac_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter logic [AW-1:0] RADDR = REG_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          code_up,
    input  feac_evt_t     evt,
    output logic [7:0]    rd_data,
    output logic          irq
);
    logic     hit_rd, hit_wr;
    logic     val_st, rem_st, val_en, rem_en;
    ctl_reg_t image, wr_img;
    logic     unused_wr_bits;

    assign hit_rd = rd_en && (addr == RADDR);
    assign hit_wr = wr_en && (addr == RADDR);
    assign wr_img = ctl_reg_t'(wr_data);
    assign unused_wr_bits = ^{wr_img.spare, wr_img.code_up, wr_img.rem_st, wr_img.val_st};

    always_ff @(posedge clk) begin
        if (rst) begin
            val_st <= 1'b0;
            rem_st <= 1'b0;
            val_en <= 1'b0;
            rem_en <= 1'b0;
        end else begin
            val_st <= evt.validate | (val_st & ~hit_rd);
            rem_st <= evt.remove   | (rem_st & ~hit_rd);
            if (hit_wr) begin
                val_en <= wr_img.val_en;
                rem_en <= wr_img.rem_en;
            end
        end
    end

    always_comb begin
        image         = '0;
        image.code_up = code_up;
        image.rem_en  = rem_en;
        image.rem_st  = rem_st;
        image.val_en  = val_en;
        image.val_st  = val_st;
        rd_data       = hit_rd ? 8'(image) : 8'h00;
    end

    assign irq = (val_st & val_en) | (rem_st & rem_en);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        evt.validate |=> val_st);
    // R5
    stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (val_st && !hit_rd) |=> val_st);
    // R5
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_rd && !evt.remove) |=> !rem_st);
    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!val_en && !rem_en) |-> !irq);
    // R4
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:5] == 3'b000);
endmodule

// File: rtl/feac_monitor.sv
module feac_monitor
    import feac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              code_stb,
    input  logic [CODE_W-1:0] code_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              irq,
    output logic [CODE_W-1:0] valid_code
);
    cnt_t      match_cnt, diff_cnt;
    logic      code_up;
    feac_evt_t evt;

    feac_window #(.CW(CODE_W), .WN(WIN), .NW(CNT_W)) u_window (
        .clk(clk), .rst(rst), .stb(code_stb), .code_in(code_in),
        .ref_code(valid_code), .match_cnt(match_cnt), .diff_cnt(diff_cnt)
    );

    feac_decide #(.CW(CODE_W), .NW(CNT_W), .VMIN(VALID_MIN), .RMIN(REMOVE_MIN)) u_decide (
        .clk(clk), .rst(rst), .stb(code_stb), .code_in(code_in),
        .match_cnt(match_cnt), .diff_cnt(diff_cnt),
        .code_up(code_up), .code_held(valid_code), .evt(evt)
    );

    feac_regs #(.AW(ADDR_W), .RADDR(REG_ADDR)) u_regs (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .code_up(code_up), .evt(evt),
        .rd_data(rd_data), .irq(irq)
    );
endmodule

// File: tb/feac_monitor_bench.sv
module feac_monitor_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       code_stb = 1'b0;
    logic [5:0] code_in = '0;
    logic [7:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;
    logic [5:0] valid_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0] q_exp [$];
    string      q_tag [$];

    localparam logic [5:0] CA = 6'h05;
    localparam logic [5:0] CB = 6'h2A;
    localparam logic [5:0] CC = 6'h3F;

    always #5 clk = ~clk;

    feac_monitor u_feac_monitor (
        .clk(clk), .rst(rst), .code_stb(code_stb), .code_in(code_in),
        .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .valid_code(valid_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compares read data in the middle of each read cycle
    always @(negedge clk) begin
        #2;
        if (rd_en) begin
            if (q_exp.size() == 0) chk(1'b0, "scoreboard-empty", rd_data, 0);
            else begin
                logic [7:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                chk(rd_data == e, t, rd_data, e);
            end
        end
    end

    task automatic strobe(input logic [5:0] c, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            code_stb = 1'b1;
            code_in  = c;
            @(negedge clk);
            code_stb = 1'b0;
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic stb_rd(input logic [5:0] c, input logic [7:0] e, input string tag);
        @(negedge clk);
        code_stb = 1'b1;
        code_in  = c;
        addr     = 8'h13;
        rd_en    = 1'b1;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        code_stb = 1'b0;
        rd_en    = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        addr    = 8'h13;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pins(input logic exp_irq, input logic [5:0] exp_code, input string tag);
        #1;
        chk(irq == exp_irq, {tag, " irq"}, irq, exp_irq);
        chk(valid_code == exp_code, {tag, " code"}, valid_code, exp_code);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        pins(1'b0, 6'h00, "R10");
        rd(8'h13, 8'h00, "R10 reset read");

        // R11 seven matching words only
        strobe(CA, 7);
        rd(8'h13, 8'h00, "R11 seven of ten");
        // R1 eighth word validates; R9 recorded while disabled
        strobe(CA, 1);
        pins(1'b0, CA, "R9 R1");
        wr(8'h02);
        pins(1'b1, CA, "R7 enable raises");
        rd(8'h13, 8'h13, "R1 validate status");
        pins(1'b0, CA, "R5 after clear");
        rd(8'h13, 8'h12, "R5 cleared");

        // R2 more of the same code: no new event
        strobe(CA, 2);
        rd(8'h13, 8'h12, "R2 repeat code");

        // R3 removal at third differing word
        wr(8'h0A);
        strobe(CB, 2);
        rd(8'h13, 8'h1A, "R3 two differ");
        strobe(CB, 1);
        pins(1'b1, CA, "R7 R3 removal");
        rd(8'h13, 8'h0E, "R3 removal status");

        // R2 previously validated code cannot return
        strobe(CA, 10);
        rd(8'h13, 8'h0A, "R2 after removal");

        // R8 new code validated during a read
        strobe(CB, 7);
        stb_rd(CB, 8'h0A, "R8 read during event");
        pins(1'b1, CB, "R8 R1");
        rd(8'h13, 8'h1B, "R8 event kept");

        // R9 removal with interrupts disabled
        wr(8'h00);
        pins(1'b0, CB, "R6 disable");
        strobe(CC, 3);
        pins(1'b0, CB, "R9 masked");
        rd(8'h14, 8'h00, "R4 other address");
        rd(8'h13, 8'h04, "R5 R9 not cleared by other address");
        rd(8'h13, 8'h00, "R5 cleared");

        // R6 only enable bits are writable; R4 spare bits zero
        wr(8'hFF);
        rd(8'h13, 8'h0A, "R6 R4 write all ones");
        @(negedge clk);
        #1;
        chk(rd_data == 8'h00, "R4 idle read data", rd_data, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule